// File: doc/BRIEF.md
# Four-Channel Register-Programmed PWM Generator

This block produces four independent pulse-width-modulated outputs. Software programs them through a small 32-bit register bus with select, write enable, address, write data and read data. Each channel has two counts, both measured in input clock ticks: a cycle length and a high time. Each channel also has its own polarity bit, run bit and output-enable bit. A running channel counts from zero up to its cycle length minus one. Its output is high while the count is below the high time, and the polarity bit is applied to the result of that comparison.

New counts written while a channel runs are held in the programmed registers. They move into the channel's working (shadow) copy only when the current cycle ends, so the waveform never shows a partial cycle. A channel whose cycle length is zero is parked: it stops and holds its output high. Clearing a channel's run bit also holds the output high. In that state the counter stays at zero and the shadow copy follows the programmed counts every clock. Setting the run bit again therefore starts a fresh cycle at once with the newest counts.

A write happens on the rising clock edge when select and write enable are both high. Read data is a combinational function of the address.

Top module: `pwm_bank_apb`

## Requirements
- R1: After reset every count register and every bit register reads zero, all four outputs are high and all four output-enable lines are low.
- R2: Channel n has its high-time register at byte offset n*8 and its cycle-length register at n*8+4. The polarity bits are at 0x40, the run bits at 0x44 and the output-enable bits at 0xD0, with channel n in bit n and the upper bits reading zero. Any other offset, including one that is not word aligned, reads zero, and a write to it changes no register and no output.
- R3: One clock after its run bit is set, a running channel with cycle length P>0 and high time H<P is high for H clocks and then low for P-H clocks, and repeats this pattern.
- R4: When H>=P the output stays high for the whole cycle, and when H=0 it stays low.
- R5: Counts written while a channel runs do not alter the cycle in progress. They take effect from the first clock of the next cycle.
- R6: A cycle length of zero parks the channel with its output high, whatever the high time is. A running channel that is given a zero length parks at the end of its current cycle. A parked channel with its run bit set starts counting from zero two clocks after a nonzero length is written.
- R7: A set polarity bit inverts a running channel's waveform. The parked and idle levels stay high.
- R8: While its run bit is clear, a channel's output is high. Setting the bit starts a new cycle at count zero on the next clock, using the counts programmed at that moment, even if the previous cycle was unfinished.
- R9: Each output-enable line follows its bit in the output-enable register from the clock after the write.
- R10: Channels run independently. Two channels started together each produce their own pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register bus select |
| pwrite | input | 1 | Write enable; a write happens when this and psel are high at a rising edge |
| paddr | input | AW (8) | Byte address |
| pwdata | input | DW (32) | Write data |
| prdata | output | DW (32) | Read data for paddr, combinational |
| pwm_out | output | NCH (4) | One waveform output per channel |
| pwm_oe | output | NCH (4) | One output-enable line per channel |

## Verification
A wrong counter or shadow value shows on the pin within one cycle length. Either the high/low split is wrong or the period wraps at the wrong place, so every sweep sample checks the exact clock. A reload that happens too early shows as a truncated cycle at the clock where a write lands. A reload that happens too late shows as an extra old-pattern cycle, and the deferred-update and park tests look for both at a known count. A broken idle or restart path shows one clock after the run bit toggles, as a low output or a pattern that does not begin at count zero.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam logic [31:0] OFS_POL    = 32'h40;
  localparam logic [31:0] OFS_RUN    = 32'h44;
  localparam logic [31:0] OFS_OE     = 32'hD0;
  localparam int unsigned CH_STRIDE  = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HIGH,
    SEL_PERIOD,
    SEL_POL,
    SEL_RUN,
    SEL_OE
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [7:0] idx;
  } reg_hit_t;

  // Map a byte address to a register kind and channel index.
  function automatic reg_hit_t decode_addr(input logic [31:0] a, input int unsigned nch);
    reg_hit_t h;
    h.sel = SEL_NONE;
    h.idx = a[10:3];
    if (a[1:0] == 2'b00) begin
      if (a < nch * CH_STRIDE)  h.sel = a[2] ? SEL_PERIOD : SEL_HIGH;
      else if (a == OFS_POL)    h.sel = SEL_POL;
      else if (a == OFS_RUN)    h.sel = SEL_RUN;
      else if (a == OFS_OE)     h.sel = SEL_OE;
    end
    return h;
  endfunction

  // Raw comparison level, then polarity.
  function automatic logic tick_level(input logic [31:0] cnt, input logic [31:0] hi,
                                      input logic inv);
    return (cnt < hi) ^ inv;
  endfunction

  // Count value at which a cycle of length per ends.
  function automatic logic [31:0] last_tick(input logic [31:0] per);
    return per - 32'd1;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wen,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] hi_o  [NCH],
  output logic [CW-1:0] per_o [NCH],
  output logic [NCH-1:0] pol_o,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] oe_o
);

  localparam int unsigned FLAT_W = 2 * NCH * CW + 3 * NCH;

  reg_hit_t       hit;
  logic           wr_fire;
  logic           wr_unmapped;
  logic [CW-1:0]  hi_q  [NCH];
  logic [CW-1:0]  per_q [NCH];
  logic [NCH-1:0] pol_q, run_q, oe_q;
  logic [FLAT_W-1:0] flat;

  assign hit         = decode_addr(32'(addr), NCH);
  assign wr_fire     = sel && wen;
  assign wr_unmapped = wr_fire && (hit.sel == SEL_NONE);

  for (genvar c = 0; c < NCH; c++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[c]  <= '0;
        per_q[c] <= '0;
      end else if (wr_fire && hit.idx == 8'(c)) begin
        if (hit.sel == SEL_HIGH)   hi_q[c]  <= wdata[CW-1:0];
        if (hit.sel == SEL_PERIOD) per_q[c] <= wdata[CW-1:0];
      end
    end
    assign hi_o[c]  = hi_q[c];
    assign per_o[c] = per_q[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      run_q <= '0;
      oe_q  <= '0;
    end else if (wr_fire) begin
      case (hit.sel)
        SEL_POL: pol_q <= wdata[NCH-1:0];
        SEL_RUN: run_q <= wdata[NCH-1:0];
        SEL_OE:  oe_q  <= wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  assign pol_o = pol_q;
  assign run_o = run_q;
  assign oe_o  = oe_q;

  always_comb begin
    rdata = '0;
    case (hit.sel)
      SEL_HIGH, SEL_PERIOD: begin
        for (int c = 0; c < NCH; c++) begin
          if (hit.idx == 8'(c))
            rdata = DW'((hit.sel == SEL_HIGH) ? hi_q[c] : per_q[c]);
        end
      end
      SEL_POL: rdata = DW'(pol_q);
      SEL_RUN: rdata = DW'(run_q);
      SEL_OE:  rdata = DW'(oe_q);
      default: rdata = '0;
    endcase
  end

  // Flattened register state, used only to check that stray writes touch nothing.
  always_comb begin
    flat = '0;
    for (int c = 0; c < NCH; c++) begin
      flat[c*2*CW +: CW]      = hi_q[c];
      flat[c*2*CW + CW +: CW] = per_q[c];
    end
    flat[FLAT_W-1 -: 3*NCH] = {pol_q, run_q, oe_q};
  end

  assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(flat));

  assert_oe_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && hit.sel == SEL_OE) |=> (oe_q == $past(wdata[NCH-1:0])));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          inv,
  input  logic [CW-1:0] prog_hi,
  input  logic [CW-1:0] prog_per,
  output logic          pwm,
  output logic          running_o,
  output logic          wrap_o
);

  logic [CW-1:0] cnt_q, sh_hi_q, sh_per_q;
  logic          parked, running, wrap, reload;

  assign parked  = (sh_per_q == '0);
  assign running = run && !parked;
  assign wrap    = running && (32'(cnt_q) == last_tick(32'(sh_per_q)));
  assign reload  = !running || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_hi_q  <= '0;
      sh_per_q <= '0;
    end else begin
      if (reload) begin
        sh_hi_q  <= prog_hi;
        sh_per_q <= prog_per;
        cnt_q    <= '0;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  assign pwm       = running ? tick_level(32'(cnt_q), 32'(sh_hi_q), inv) : 1'b1;
  assign running_o = running;
  assign wrap_o    = wrap;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < sh_per_q));

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap) |=> ($stable(sh_hi_q) && $stable(sh_per_q)));

  assert_shadow_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (sh_per_q == $past(prog_per) && sh_hi_q == $past(prog_hi)));

  assert_idle_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_bank_apb.sv
module pwm_bank_apb
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           psel,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [DW-1:0]  pwdata,
  output logic [DW-1:0]  prdata,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_oe
);

  logic [CW-1:0]  prog_hi  [NCH];
  logic [CW-1:0]  prog_per [NCH];
  logic [NCH-1:0] pol, run, oe;
  logic [NCH-1:0] ch_running, ch_wrap;

  pwm_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (psel),
    .wen   (pwrite),
    .addr  (paddr),
    .wdata (pwdata),
    .rdata (prdata),
    .hi_o  (prog_hi),
    .per_o (prog_per),
    .pol_o (pol),
    .run_o (run),
    .oe_o  (oe)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run[c]),
      .inv       (pol[c]),
      .prog_hi   (prog_hi[c]),
      .prog_per  (prog_per[c]),
      .pwm       (pwm_out[c]),
      .running_o (ch_running[c]),
      .wrap_o    (ch_wrap[c])
    );

    assert_rest_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_running[c] |-> pwm_out[c]);

    assert_wrap_only_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_wrap[c] |-> run[c]);
  end

  assign pwm_oe = oe;

endmodule

// File: tb/sim_pwm_bank_apb.sv
module sim_pwm_bank_apb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [3:0]  pwm_out;
  logic [3:0]  pwm_oe;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [3:0] run_bits = '0;

  pwm_bank_apb u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  function automatic logic lvl(input int i, input int p, input int h, input logic inv);
    if (p == 0) return 1'b1;
    return ((i % p) < h) ? ~inv : inv;
  endfunction

  // Samples n consecutive clocks starting at sample 0 of a cycle.
  task automatic wave(input int ch, input int p, input int h, input logic inv,
                      input int n, input string req);
    int   bad = 0;
    int   at = 0;
    logic e, a0 = 1'b0, e0 = 1'b0;
    for (int i = 0; i < n; i++) begin
      e = lvl(i, p, h, inv);
      if (pwm_out[ch] !== e) begin
        if (bad == 0) begin a0 = pwm_out[ch]; e0 = e; at = i; end
        bad++;
      end
      @(negedge clk);
    end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s ch=%0d P=%0d H=%0d sample=%0d actual=%b expected=%b",
               req, ch, p, h, at, a0, e0);
    end
  endtask

  task automatic launch(input int ch, input int p, input int h);
    run_bits[ch] = 1'b0; wr(8'h44, 32'(run_bits));
    wr(8'(ch * 8), 32'(h));
    wr(8'(ch * 8 + 4), 32'(p));
    run_bits[ch] = 1'b1; wr(8'h44, 32'(run_bits));
  endtask

  initial begin
    #(10 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bad;
    logic [7:0] stray [5];
    stray[0] = 8'h20; stray[1] = 8'h48; stray[2] = 8'hD4;
    stray[3] = 8'h41; stray[4] = 8'h3C;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out in reset", 32'(pwm_out), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out", 32'(pwm_out), 32'hF);
    chk("R1 oe", 32'(pwm_oe), 32'h0);
    for (int a = 0; a < 32; a += 4) begin
      rd(8'(a), d); chk("R1 count reg", d, 0);
    end
    rd(8'h40, d); chk("R1 pol", d, 0);
    rd(8'h44, d); chk("R1 run", d, 0);
    rd(8'hD0, d); chk("R1 oe reg", d, 0);
    @(negedge clk);

    // R2: map, readback, stray accesses
    for (int c = 0; c < 4; c++) begin
      wr(8'(c * 8),     32'hA500_0000 + 32'(c * 17 + 1));
      wr(8'(c * 8 + 4), 32'h5A00_0000 + 32'(c * 29 + 3));
    end
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R2 pol width", d, 32'hF);
    @(negedge clk);
    wr(8'h40, 32'h0);
    for (int s = 0; s < 5; s++) wr(stray[s], 32'hFFFF_FFFF);
    for (int s = 0; s < 5; s++) begin
      rd(stray[s], d); chk("R2 stray read", d, 0);
    end
    bad = 0;
    for (int c = 0; c < 4; c++) begin
      rd(8'(c * 8), d);     if (d !== 32'hA500_0000 + 32'(c * 17 + 1)) bad++;
      rd(8'(c * 8 + 4), d); if (d !== 32'h5A00_0000 + 32'(c * 29 + 3)) bad++;
    end
    chk("R2 count readback", 32'(bad), 0);
    rd(8'h40, d); chk("R2 pol untouched", d, 0);
    rd(8'h44, d); chk("R2 run untouched", d, 0);
    rd(8'hD0, d); chk("R2 oe untouched", d, 0);
    chk("R2 outputs untouched", {pwm_oe, pwm_out}, 32'h0F);
    @(negedge clk);

    // R3 / R4: sweep on channel 0
    for (int p = 1; p <= 6; p++) begin
      for (int h = 0; h <= 7; h++) begin
        launch(0, p, h);
        wave(0, p, h, 1'b0, 2 * p + 2, (h >= p || h == 0) ? "R4 flat" : "R3 pattern");
      end
    end

    // R5: deferred update; P=6,H=2 then H=3,P=4 written mid-cycle
    launch(0, 6, 2);
    bad = 0;
    for (int i = 0; i < 18; i++) begin
      logic e;
      e = (i < 6) ? lvl(i, 6, 2, 1'b0) : lvl(i - 6, 4, 3, 1'b0);
      if (pwm_out[0] !== e) bad++;
      if (i == 2) begin psel = 1; pwrite = 1; paddr = 8'h00; pwdata = 32'd3; end
      else if (i == 3) begin paddr = 8'h04; pwdata = 32'd4; end
      else begin psel = 0; pwrite = 0; end
      @(negedge clk);
    end
    chk("R5 deferred mismatches", 32'(bad), 0);

    // R8: new counts then run bit cleared and set again restarts at once
    wr(8'h00, 32'd1);
    wr(8'h04, 32'd5);
    run_bits[0] = 1'b0; wr(8'h44, 32'(run_bits));
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      if (pwm_out[0] !== 1'b1) bad++;
      @(negedge clk);
    end
    chk("R8 idle high", 32'(bad), 0);
    run_bits[0] = 1'b1; wr(8'h44, 32'(run_bits));
    wave(0, 5, 1, 1'b0, 12, "R8 restart");

    // R6: zero length while running parks after the cycle ends (now at count 2)
    wr(8'h04, 32'd0);
    wr(8'h00, 32'd0);
    chk("R6 cycle finishes", 32'(pwm_out[0]), 32'd0);
    @(negedge clk);
    wave(0, 0, 0, 1'b0, 8, "R6 parked");
    wr(8'h00, 32'd5);
    wave(0, 0, 5, 1'b0, 6, "R6 parked with high time");
    wr(8'h00, 32'd0);
    wr(8'h04, 32'd3);
    chk("R6 still parked one clock", 32'(pwm_out[0]), 32'd1);
    @(negedge clk);
    wave(0, 3, 0, 1'b0, 6, "R6 leaves park");

    // R7: polarity on channel 2, idle and parked stay high
    wr(8'h40, 32'h4);
    launch(2, 5, 2);
    wave(2, 5, 2, 1'b1, 15, "R7 inverted");
    run_bits[2] = 1'b0; wr(8'h44, 32'(run_bits));
    wave(2, 0, 0, 1'b1, 4, "R7 idle high inverted");
    launch(2, 0, 3);
    wave(2, 0, 3, 1'b1, 5, "R7 parked high inverted");
    wr(8'h40, 32'h0);

    // R10: channels 1 and 3 started together
    run_bits[1] = 1'b0; run_bits[3] = 1'b0; wr(8'h44, 32'(run_bits));
    wr(8'h08, 32'd2); wr(8'h0C, 32'd5);
    wr(8'h18, 32'd3); wr(8'h1C, 32'd4);
    run_bits[1] = 1'b1; run_bits[3] = 1'b1; wr(8'h44, 32'(run_bits));
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out[1] !== lvl(i, 5, 2, 1'b0)) bad++;
      if (pwm_out[3] !== lvl(i, 4, 3, 1'b0)) bad++;
      @(negedge clk);
    end
    chk("R10 two channels", 32'(bad), 0);

    // R9: output enables
    wr(8'hD0, 32'h5);
    chk("R9 oe 0101", 32'(pwm_oe), 32'h5);
    wr(8'hD0, 32'hFFFF_FFFA);
    chk("R9 oe 1010", 32'(pwm_oe), 32'hA);
    rd(8'hD0, d); chk("R9 oe readback", d, 32'hA);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule